// File: doc/BRIEF.md
# Shuffle-Exchange Permutation Stage

This block joins n = 2^k node ports through two kinds of fixed link. A perfect-shuffle link takes the word on node i to node 2i mod (n-1). Node n-1 maps to itself, and so does node 0. Put another way, the shuffle rotates the k address bits one place to the left, so the top bit becomes the bottom bit. An exchange link joins two nodes whose addresses differ only in the least significant bit. Every port can carry one word per cycle. A single select input chooses, for that cycle, which link all the words follow. The permuted words appear at the outputs one clock later.

Beside the data stage there is a routing sequencer. It traces one word from a source node to a destination node along these links, one link traversal per cycle. Each round it sets the address LSB to the next destination bit, taken most significant first, with an exchange when the bit differs. It then shuffles, except in the last round. The walk therefore takes at most k exchanges and k-1 shuffles, 2k-1 steps in all. The walk stops as soon as the current address equals the destination, and a done flag then holds until the next request.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block, so the block starts working on the third rising edge after the release.

Top module: `shex_stage`

## Requirements
- R1: While reset is held and after it is released, until inputs act: out_valid is all zero, out_data is zero, rt_busy and rt_done are 0, rt_cur is 0 and rt_steps is 0.
- R2: With link_sel = 0 (shuffle) at a clock edge, the word and valid bit on input port i appear after that edge on output port rotl(i). Here rotl(i) = ((i << 1) | (i >> (k-1))) mod n.
- R3: Under the shuffle, port 0 and port n-1 keep their own word.
- R4: With link_sel = 1 (exchange) at a clock edge, the word and valid bit on input port i appear after that edge on output port i XOR 1.
- R5: An output port whose source input is not valid shows out_valid = 0 and out_data = 0.
- R6: rt_start while idle loads rt_src and rt_dst. Each busy cycle does one phase: an exchange phase sets the LSB to destination bit k-1-r in round r, and a shuffle phase does rotl. After any phase that lands on rt_dst, rt_busy falls and rt_done rises. rt_done holds until the next accepted start. For every source and destination pair, rt_cur ends equal to rt_dst.
- R7: rt_steps counts the exchanges that actually flip the LSB plus the shuffles. It never exceeds 2k-1.
- R8: When rt_src equals rt_dst, rt_done is 1, rt_busy is 0 and rt_steps is 0 right after the starting edge.
- R9: rt_start is ignored while rt_busy is 1. The route in progress still ends at its own destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | N*DATA_W | Input word per node, port i at bits [i*DATA_W +: DATA_W] |
| in_valid | input | N | Input valid per node |
| link_sel | input | 1 | 0 = shuffle link, 1 = exchange link |
| out_data | output | N*DATA_W | Registered permuted words |
| out_valid | output | N | Registered permuted valid bits |
| rt_start | input | 1 | Start a route (accepted only while idle) |
| rt_src | input | ADDR_W | Route source node |
| rt_dst | input | ADDR_W | Route destination node |
| rt_busy | output | 1 | Route walk in progress |
| rt_done | output | 1 | Current address equals destination, walk finished |
| rt_cur | output | ADDR_W | Current address of the routed word |
| rt_steps | output | STEP_W | Link traversals taken so far |

## Verification
A wrong select decode or a wrong port index sends a word to the wrong output port. That shows on out_data and out_valid at the edge after the word entered, so the per-cycle comparison catches it within one cycle. In the sequencer, a wrong destination bit order or rotation direction shows on rt_cur at the first phase that uses it. A missed early stop or a miscounted no-op exchange shows on rt_steps or on the cycle rt_done rises. Running every source and destination pair drives each bit order and each fixed point through the walk.

// File: rtl/shex_pkg.sv
package shex_pkg;
  typedef enum logic {
    LINK_SHUF = 1'b0,
    LINK_EXCH = 1'b1
  } link_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EXCH = 2'd1,
    PH_SHUF = 2'd2
  } phase_e;
endpackage

// File: rtl/shex_rst_sync.sv
module shex_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/shex_port_mux.sv
module shex_port_mux #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int PORT   = 0
) (
  input  logic [(1<<ADDR_W)*DATA_W-1:0] in_data,
  input  logic [(1<<ADDR_W)-1:0]        in_valid,
  input  logic                          link_sel,
  output logic [DATA_W-1:0]             o_data,
  output logic                          o_valid
);
  import shex_pkg::*;
  localparam int NODES    = 1 << ADDR_W;
  // inverse of the left rotation: rotate the output index right by one
  localparam int SRC_SHUF = ((PORT >> 1) | ((PORT & 1) << (ADDR_W - 1))) & (NODES - 1);
  localparam int SRC_EXCH = PORT ^ 1;

  logic [DATA_W-1:0] sel_data;
  logic              sel_valid;

  always_comb begin
    if (link_e'(link_sel) == LINK_EXCH) begin
      sel_data  = in_data[SRC_EXCH*DATA_W +: DATA_W];
      sel_valid = in_valid[SRC_EXCH];
    end else begin
      sel_data  = in_data[SRC_SHUF*DATA_W +: DATA_W];
      sel_valid = in_valid[SRC_SHUF];
    end
    o_valid = sel_valid;
    o_data  = sel_valid ? sel_data : '0;
  end
endmodule

// File: rtl/shex_data_stage.sv
module shex_data_stage #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [(1<<ADDR_W)*DATA_W-1:0] in_data,
  input  logic [(1<<ADDR_W)-1:0]        in_valid,
  input  logic                          link_sel,
  output logic [(1<<ADDR_W)*DATA_W-1:0] out_data,
  output logic [(1<<ADDR_W)-1:0]        out_valid
);
  localparam int NODES = 1 << ADDR_W;

  logic [NODES*DATA_W-1:0] data_d;
  logic [NODES-1:0]        valid_d;
  logic [NODES*DATA_W-1:0] data_q;
  logic [NODES-1:0]        valid_q;
  logic                    stage_en;

  assign stage_en = 1'b1;

  for (genvar p = 0; p < NODES; p++) begin : g_port
    shex_port_mux #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .PORT  (p)
    ) u_mux (
      .in_data (in_data),
      .in_valid(in_valid),
      .link_sel(link_sel),
      .o_data  (data_d[p*DATA_W +: DATA_W]),
      .o_valid (valid_d[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= '0;
    end else if (stage_en) begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign out_data  = data_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/shex_router.sv
module shex_router #(
  parameter int ADDR_W = 3,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_start,
  input  logic [ADDR_W-1:0] rt_src,
  input  logic [ADDR_W-1:0] rt_dst,
  output logic              rt_busy,
  output logic              rt_done,
  output logic [ADDR_W-1:0] rt_cur,
  output logic [STEP_W-1:0] rt_steps
);
  import shex_pkg::*;
  localparam int RND_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [RND_W-1:0]  rnd_q, rnd_d;
  logic [STEP_W-1:0] steps_q, steps_d;
  logic              done_q, done_d;
  logic              reg_en;
  logic              want_bit;
  logic [ADDR_W-1:0] exch_addr;
  logic [ADDR_W-1:0] shuf_addr;

  always_comb begin
    want_bit  = dst_q[ADDR_W-1-int'(rnd_q)];
    exch_addr = {cur_q[ADDR_W-1:1], want_bit};
    if (ADDR_W > 1) shuf_addr = {cur_q[ADDR_W-2:0], cur_q[ADDR_W-1]};
    else            shuf_addr = cur_q;
  end

  assign reg_en = (phase_q != PH_IDLE) || rt_start;

  always_comb begin
    phase_d = phase_q;
    cur_d   = cur_q;
    dst_d   = dst_q;
    rnd_d   = rnd_q;
    steps_d = steps_q;
    done_d  = done_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (rt_start) begin
          cur_d   = rt_src;
          dst_d   = rt_dst;
          rnd_d   = '0;
          steps_d = '0;
          if (rt_src == rt_dst) begin
            done_d  = 1'b1;
            phase_d = PH_IDLE;
          end else begin
            done_d  = 1'b0;
            phase_d = PH_EXCH;
          end
        end
      end
      PH_EXCH: begin
        cur_d = exch_addr;
        if (exch_addr != cur_q) steps_d = steps_q + 1'b1;
        if (exch_addr == dst_q) begin
          done_d  = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          phase_d = PH_SHUF;
        end
      end
      PH_SHUF: begin
        cur_d   = shuf_addr;
        steps_d = steps_q + 1'b1;
        rnd_d   = rnd_q + 1'b1;
        if (shuf_addr == dst_q) begin
          done_d  = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          phase_d = PH_EXCH;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cur_q   <= '0;
      dst_q   <= '0;
      rnd_q   <= '0;
      steps_q <= '0;
      done_q  <= 1'b0;
    end else if (reg_en) begin
      phase_q <= phase_d;
      cur_q   <= cur_d;
      dst_q   <= dst_d;
      rnd_q   <= rnd_d;
      steps_q <= steps_d;
      done_q  <= done_d;
    end
  end

  assign rt_busy  = (phase_q != PH_IDLE);
  assign rt_done  = done_q;
  assign rt_cur   = cur_q;
  assign rt_steps = steps_q;
endmodule

// File: rtl/shex_stage.sv
module shex_stage #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int NODES  = 1 << ADDR_W,
  parameter int STEP_W = $clog2(2 * ADDR_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NODES*DATA_W-1:0] in_data,
  input  logic [NODES-1:0]        in_valid,
  input  logic                    link_sel,
  output logic [NODES*DATA_W-1:0] out_data,
  output logic [NODES-1:0]        out_valid,
  input  logic                    rt_start,
  input  logic [ADDR_W-1:0]       rt_src,
  input  logic [ADDR_W-1:0]       rt_dst,
  output logic                    rt_busy,
  output logic                    rt_done,
  output logic [ADDR_W-1:0]       rt_cur,
  output logic [STEP_W-1:0]       rt_steps
);
  logic rst_sync_n;

  shex_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  shex_data_stage #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_data (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .link_sel (link_sel),
    .out_data (out_data),
    .out_valid(out_valid)
  );

  shex_router #(
    .ADDR_W(ADDR_W),
    .STEP_W(STEP_W)
  ) u_route (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rt_start(rt_start),
    .rt_src  (rt_src),
    .rt_dst  (rt_dst),
    .rt_busy (rt_busy),
    .rt_done (rt_done),
    .rt_cur  (rt_cur),
    .rt_steps(rt_steps)
  );
endmodule

// File: rtl/shex_stage_chk.sv
module shex_stage_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int NODES  = 1 << ADDR_W,
  parameter int STEP_W = 3
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic [NODES*DATA_W-1:0] in_data,
  input logic [NODES-1:0]        in_valid,
  input logic                    link_sel,
  input logic [NODES*DATA_W-1:0] out_data,
  input logic [NODES-1:0]        out_valid,
  input logic                    rt_start,
  input logic [ADDR_W-1:0]       rt_dst,
  input logic                    rt_busy,
  input logic                    rt_done,
  input logic [ADDR_W-1:0]       rt_cur,
  input logic [STEP_W-1:0]       rt_steps
);
  localparam int MAX_STEPS = 2 * ADDR_W - 1;
  logic [ADDR_W-1:0] want_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)              want_q <= '0;
    else if (rt_start && !rt_busy) want_q <= rt_dst;
  end

  AST_SHUF_FIX_LO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !link_sel |=> (out_valid[0] == $past(in_valid[0]))); // R3
  AST_SHUF_FIX_HI: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !link_sel |=> (out_valid[NODES-1] == $past(in_valid[NODES-1]))); // R3
  AST_EXCH_PAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (link_sel && in_valid[1]) |=> (out_data[DATA_W-1:0] == $past(in_data[2*DATA_W-1:DATA_W]))); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!out_valid[0]) |-> (out_data[DATA_W-1:0] == '0)); // R5
  AST_DONE_AT_DST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rt_done |-> (rt_cur == want_q)); // R6
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rt_busy && rt_done)); // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int'(rt_steps) <= MAX_STEPS); // R7
  AST_STEP_MONO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rt_busy |=> (rt_steps >= $past(rt_steps))); // R7
  AST_HOLD_DST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rt_busy && rt_start) |=> $stable(want_q)); // R9
endmodule

bind shex_stage shex_stage_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .NODES (NODES),
  .STEP_W(STEP_W)
) u_chk (.*);

// File: tb/shex_stage_tb.sv
module shex_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K   = 3;
  localparam int DW  = 8;
  localparam int N   = 1 << K;
  localparam int SW  = $clog2(2 * K);

  logic            clk;
  logic            rst_n;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    in_valid;
  logic            link_sel;
  logic [N*DW-1:0] out_data;
  logic [N-1:0]    out_valid;
  logic            rt_start;
  logic [K-1:0]    rt_src;
  logic [K-1:0]    rt_dst;
  logic            rt_busy;
  logic            rt_done;
  logic [K-1:0]    rt_cur;
  logic [SW-1:0]   rt_steps;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int rel_edges = 0;
  bit model_on = 0;

  // reference model state
  int m_dv[N];
  int m_dd[N];
  int m_link;
  int m_phase;   // 0 idle, 1 exchange, 2 shuffle
  int m_cur, m_dst, m_rnd, m_steps, m_done;

  shex_stage #(.ADDR_W(K), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .link_sel(link_sel), .out_data(out_data), .out_valid(out_valid),
    .rt_start(rt_start), .rt_src(rt_src), .rt_dst(rt_dst),
    .rt_busy(rt_busy), .rt_done(rt_done), .rt_cur(rt_cur), .rt_steps(rt_steps)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int rotl(int a);
    return ((a << 1) | (a >> (K - 1))) & (N - 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_dv[i] = 0; m_dd[i] = 0; end
    m_link = 0; m_phase = 0; m_cur = 0; m_dst = 0; m_rnd = 0; m_steps = 0; m_done = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) rel_edges = 0; else rel_edges++;
    if (rel_edges <= 2) model_reset();
    else begin
      m_link = int'(link_sel);
      for (int i = 0; i < N; i++) begin
        int d;
        d = link_sel ? (i ^ 1) : rotl(i);
        m_dv[d] = int'(in_valid[i]);
        m_dd[d] = in_valid[i] ? int'(in_data[i*DW +: DW]) : 0;
      end
      case (m_phase)
        0: if (rt_start) begin
             m_cur = int'(rt_src); m_dst = int'(rt_dst); m_rnd = 0; m_steps = 0;
             if (m_cur == m_dst) m_done = 1;
             else begin m_done = 0; m_phase = 1; end
           end
        1: begin
             int nc;
             nc = (m_cur & ~1) | ((m_dst >> (K - 1 - m_rnd)) & 1);
             if (nc != m_cur) m_steps++;
             m_cur = nc;
             if (m_cur == m_dst) begin m_done = 1; m_phase = 0; end
             else m_phase = 2;
           end
        default: begin
             m_cur = rotl(m_cur); m_steps++; m_rnd++;
             if (m_cur == m_dst) begin m_done = 1; m_phase = 0; end
             else m_phase = 1;
           end
      endcase
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      for (int i = 0; i < N; i++) begin
        string tg;
        tg = (m_dv[i] == 0) ? "R5" : (m_link != 0 ? "R4" : "R2");
        check({tg, " out_valid"}, int'(out_valid[i]), m_dv[i]);
        check({tg, " out_data"}, int'(out_data[i*DW +: DW]), m_dd[i]);
      end
      check("R6 rt_cur", int'(rt_cur), m_cur);
      check("R6 rt_busy", int'(rt_busy), int'(m_phase != 0));
      check("R6 rt_done", int'(rt_done), m_done);
      check("R7 rt_steps", int'(rt_steps), m_steps);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic route(input int s, input int d);
    int guard;
    @(negedge clk);
    rt_start = 1; rt_src = K'(s); rt_dst = K'(d);
    @(negedge clk);
    rt_start = 0;
    if (s == d) begin
      check("R8 done", int'(rt_done), 1);
      check("R8 busy", int'(rt_busy), 0);
      check("R8 steps", int'(rt_steps), 0);
    end
    guard = 0;
    while (rt_busy && guard < 20) begin @(negedge clk); guard++; end
    check("R6 final addr", int'(rt_cur), d);
    check("R6 done", int'(rt_done), 1);
    check("R7 bound", int'(int'(rt_steps) <= 2 * K - 1), 1);
  endtask

  initial begin
    rst_n = 0; in_data = '0; in_valid = '0; link_sel = 0;
    rt_start = 0; rt_src = '0; rt_dst = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset busy", int'(rt_busy), 0);
    check("R1 reset done", int'(rt_done), 0);
    check("R1 reset steps", int'(rt_steps), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 post-release cur", int'(rt_cur), 0);
    check("R1 post-release data", int'(out_data), 0);
    model_on = 1;

    // fixed points of the shuffle
    in_valid = '0; in_valid[0] = 1; in_valid[N-1] = 1;
    in_data[0 +: DW] = 8'hA5; in_data[(N-1)*DW +: DW] = 8'h3C; link_sel = 0;
    @(negedge clk);
    check("R3 port0", int'(out_data[0 +: DW]), 8'hA5);
    check("R3 portN-1", int'(out_data[(N-1)*DW +: DW]), 8'h3C);

    // full shuffle and full exchange with all ports valid
    for (int i = 0; i < N; i++) in_data[i*DW +: DW] = DW'(i + 16);
    in_valid = '1; link_sel = 0;
    @(negedge clk);
    link_sel = 1;
    @(negedge clk);
    // random mixes of valid, data and link choice
    for (int c = 0; c < 200; c++) begin
      in_valid = N'($urandom);
      for (int i = 0; i < N; i++) in_data[i*DW +: DW] = DW'($urandom);
      link_sel = 1'($urandom);
      @(negedge clk);
    end
    in_valid = '0;

    // every source and destination pair
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++)
        route(s, d);

    // start while busy is ignored
    @(negedge clk);
    rt_start = 1; rt_src = K'(1); rt_dst = K'(6);
    @(negedge clk);
    rt_src = K'(0); rt_dst = K'(0);
    @(negedge clk);
    rt_start = 0;
    for (int g = 0; g < 20 && rt_busy; g++) @(negedge clk);
    check("R9 route kept", int'(rt_cur), 6);
    check("R9 done", int'(rt_done), 1);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule